// File: doc/BRIEF.md
# Hysteretic Digital Lock Detector

This block decides whether a phase-locked loop has settled. It watches the pump-up and pump-down pulses that the phase-frequency detector produces. It measures their width by counting cycles of a fast sampling clock. A one-cycle strobe marks the end of each reference comparison, and the block classifies the comparison when that strobe arrives.

Lock is declared only after an unbroken run of comparisons whose error is below an entry threshold. Once lock is declared, only a single comparison whose error is above a larger exit threshold removes it. A mode input chooses whether the run must be three or five comparisons long. Placing the charge pump in its high-impedance state, or powering the loop down, forces the detector back to the unlocked state at once.

Both thresholds are parameters given in sampling-clock cycles. They are set so that they match the intended time limits at the chosen sampling rate.

Top module: `lock_detector`

## Requirements
- R1: After reset `lockFlag` is low.
- R2: The error of a comparison is the number of sampling cycles in which `pumpUp` or `pumpDn` is high. The count runs from the cycle after the previous `cmpDone` strobe up to and including the strobe cycle, and up and down cycles add together.
- R3: With `precisionSel` = 0, the detector is unlocked, and three consecutive comparisons each have error < `ENTRY_LIMIT`: `lockFlag` rises at the clock edge that samples the third strobe, and not earlier.
- R4: With `precisionSel` = 1, five consecutive comparisons with error < `ENTRY_LIMIT` are needed. `lockFlag` rises at the edge that samples the fifth strobe.
- R5: While the detector is unlocked, a comparison with error >= `ENTRY_LIMIT` leaves it unlocked and restarts the consecutive count from zero.
- R6: While the detector is locked, a comparison with error > `EXIT_LIMIT` clears `lockFlag` at the edge that samples its strobe.
- R7: While the detector is locked, a comparison with error <= `EXIT_LIMIT` keeps `lockFlag` high. This includes errors from `ENTRY_LIMIT` to `EXIT_LIMIT`.
- R8: `tristateEn` or `powerDown` high at a clock edge forces `lockFlag` low at that edge. It also discards the consecutive count and the partly measured error.
- R9: Apart from R8, `lockFlag` changes only at edges where `cmpDone` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pumpUp | input | 1 | Pump-up pulse from the phase detector |
| pumpDn | input | 1 | Pump-down pulse from the phase detector |
| cmpDone | input | 1 | One-cycle strobe closing a reference comparison |
| precisionSel | input | 1 | 0: three good comparisons to lock, 1: five |
| tristateEn | input | 1 | Charge pump high-impedance request, forces unlock |
| powerDown | input | 1 | Loop power-down (either mode), forces unlock |
| lockFlag | output | 1 | High while lock is declared |

## Verification
The checker measures each comparison's error itself and checks several rules on every cycle. While locked, a strobe carrying an error above the exit limit must drop lock, and one at or below that limit must keep it. An unlocked strobe with an error at or above the entry limit must not raise lock. Any change of `lockFlag` must follow a strobe or a forced reset, and a forced reset must always leave the flag low.

Some behaviour can only be shown by the bench's directed scenarios. These are the exact run length of three or five good comparisons, the restart of the run after a marginal comparison, and the loss of a partial run when a forced reset interrupts it.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_HELD = 1'b1
  } lockState_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic runInc;
    logic runClr;
    logic widthClr;
  } ldStrobe_t;

endpackage

// File: rtl/lockdet_datapath.sv
module lockdet_datapath
  import lockdet_pkg::*;
#(
  parameter int ENTRY_LIMIT = 3,
  parameter int EXIT_LIMIT  = 6,
  parameter int RUN_SHORT   = 3,
  parameter int RUN_LONG    = 5
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      pumpUp,
  input  logic      pumpDn,
  input  logic      precisionSel,
  input  ldStrobe_t strobes,
  output logic      errSmall,
  output logic      errLarge,
  output logic      goalNext
);

  localparam int WIDTH_SAT = EXIT_LIMIT + 1;
  localparam int W_W       = $clog2(WIDTH_SAT + 1);
  localparam int ERR_W     = W_W + 1;
  localparam int RUN_MAX   = (RUN_LONG > RUN_SHORT) ? RUN_LONG : RUN_SHORT;
  localparam int RUN_W     = $clog2(RUN_MAX + 1);

  localparam logic [W_W-1:0]   SAT_V   = W_W'(WIDTH_SAT);
  localparam logic [ERR_W-1:0] ENTRY_V = ERR_W'(ENTRY_LIMIT);
  localparam logic [ERR_W-1:0] EXIT_V  = ERR_W'(EXIT_LIMIT);

  logic             pumpActive;
  logic [W_W-1:0]   widthCnt;
  logic [ERR_W-1:0] errNow;
  logic [RUN_W-1:0] runCnt;
  logic [RUN_W-1:0] reqCount;
  logic [RUN_W:0]   runPlusOne;

  assign pumpActive = pumpUp | pumpDn;

  // pulse width accumulated over the current comparison window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      widthCnt <= '0;
    end else if (strobes.widthClr) begin
      widthCnt <= '0;
    end else if (pumpActive && (widthCnt != SAT_V)) begin
      widthCnt <= widthCnt + 1'b1;
    end
  end

  // error including the strobe cycle itself
  assign errNow   = {1'b0, widthCnt} + ERR_W'(pumpActive);
  assign errSmall = errNow < ENTRY_V;
  assign errLarge = errNow > EXIT_V;

  assign reqCount   = precisionSel ? RUN_W'(RUN_LONG) : RUN_W'(RUN_SHORT);
  assign runPlusOne = {1'b0, runCnt} + (RUN_W + 1)'(1);
  assign goalNext   = runPlusOne >= {1'b0, reqCount};

  // consecutive good comparison counter, saturating at the required count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt <= '0;
    end else if (strobes.runClr) begin
      runCnt <= '0;
    end else if (strobes.runInc) begin
      if (goalNext) begin
        runCnt <= reqCount;
      end else begin
        runCnt <= runPlusOne[RUN_W-1:0];
      end
    end
  end

endmodule

// File: rtl/lockdet_control.sv
module lockdet_control
  import lockdet_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmpDone,
  input  logic      tristateEn,
  input  logic      powerDown,
  input  logic      errSmall,
  input  logic      errLarge,
  input  logic      goalNext,
  output ldStrobe_t strobes,
  output logic      lockFlag
);

  lockState_t state, stateNext;
  logic       forceUnlock;

  assign forceUnlock = tristateEn | powerDown;

  always_comb begin
    strobes          = '0;
    strobes.widthClr = cmpDone | forceUnlock;
    stateNext        = state;
    if (forceUnlock) begin
      strobes.runClr = 1'b1;
      stateNext      = ST_HUNT;
    end else if (cmpDone) begin
      unique case (state)
        ST_HUNT: begin
          if (errSmall) begin
            strobes.runInc = 1'b1;
            if (goalNext) stateNext = ST_HELD;
          end else begin
            strobes.runClr = 1'b1;
          end
        end
        ST_HELD: begin
          if (errLarge) begin
            strobes.runClr = 1'b1;
            stateNext      = ST_HUNT;
          end
        end
        default: stateNext = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_HUNT;
    else       state <= stateNext;
  end

  assign lockFlag = (state == ST_HELD);

endmodule

// File: rtl/lock_detector.sv
module lock_detector
  import lockdet_pkg::*;
#(
  parameter int ENTRY_LIMIT = 3,
  parameter int EXIT_LIMIT  = 6,
  parameter int RUN_SHORT   = 3,
  parameter int RUN_LONG    = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic pumpUp,
  input  logic pumpDn,
  input  logic cmpDone,
  input  logic precisionSel,
  input  logic tristateEn,
  input  logic powerDown,
  output logic lockFlag
);

  ldStrobe_t strobes;
  logic      errSmall;
  logic      errLarge;
  logic      goalNext;

  lockdet_datapath #(
    .ENTRY_LIMIT(ENTRY_LIMIT),
    .EXIT_LIMIT (EXIT_LIMIT),
    .RUN_SHORT  (RUN_SHORT),
    .RUN_LONG   (RUN_LONG)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .pumpUp      (pumpUp),
    .pumpDn      (pumpDn),
    .precisionSel(precisionSel),
    .strobes     (strobes),
    .errSmall    (errSmall),
    .errLarge    (errLarge),
    .goalNext    (goalNext)
  );

  lockdet_control u_control (
    .clk       (clk),
    .rstN      (rstN),
    .cmpDone   (cmpDone),
    .tristateEn(tristateEn),
    .powerDown (powerDown),
    .errSmall  (errSmall),
    .errLarge  (errLarge),
    .goalNext  (goalNext),
    .strobes   (strobes),
    .lockFlag  (lockFlag)
  );

endmodule

// File: rtl/lock_detector_chk.sv
module lock_detector_chk #(
  parameter int ENTRY_LIMIT = 3,
  parameter int EXIT_LIMIT  = 6
) (
  input logic clk,
  input logic rstN,
  input logic pumpUp,
  input logic pumpDn,
  input logic cmpDone,
  input logic tristateEn,
  input logic powerDown,
  input logic lockFlag
);

  logic [15:0] errAcc;
  logic [16:0] errChk;
  logic        forced;

  assign forced = tristateEn | powerDown;
  assign errChk = {1'b0, errAcc} + 17'(pumpUp | pumpDn);

  // independent measurement of the error in each window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        errAcc <= '0;
    else if (cmpDone || forced)       errAcc <= '0;
    else if ((pumpUp || pumpDn) && errAcc != 16'hFFFF) errAcc <= errAcc + 1'b1;
  end

  // R6: a large error while locked drops lock
  a_r6_large_error_drops: assert property (@(posedge clk) disable iff (!rstN)
    (lockFlag && cmpDone && !forced && errChk > 17'(EXIT_LIMIT)) |=> !lockFlag);

  // R7: a tolerable error while locked keeps lock
  a_r7_hysteresis_holds: assert property (@(posedge clk) disable iff (!rstN)
    (lockFlag && cmpDone && !forced && errChk <= 17'(EXIT_LIMIT)) |=> lockFlag);

  // R5: an unlocked comparison at or above the entry limit never locks
  a_r5_marginal_no_lock: assert property (@(posedge clk) disable iff (!rstN)
    (!lockFlag && cmpDone && errChk >= 17'(ENTRY_LIMIT)) |=> !lockFlag);

  // R8: forced reset always unlocks
  a_r8_force_unlocks: assert property (@(posedge clk) disable iff (!rstN)
    forced |=> !lockFlag);

  // R9: the flag moves only after a strobe or a forced reset
  a_r9_change_on_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lockFlag) |-> $past(cmpDone || forced));

  // R3 and R4: lock rises only from a strobe without a forced reset
  a_r3_rise_from_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockFlag) |-> $past(cmpDone && !forced));

endmodule

bind lock_detector lock_detector_chk #(
  .ENTRY_LIMIT(ENTRY_LIMIT),
  .EXIT_LIMIT (EXIT_LIMIT)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .pumpUp    (pumpUp),
  .pumpDn    (pumpDn),
  .cmpDone   (cmpDone),
  .tristateEn(tristateEn),
  .powerDown (powerDown),
  .lockFlag  (lockFlag)
);

// File: tb/lock_detector_tb.sv
module lock_detector_tb;

  localparam int ENTRY = 3;
  localparam int EXITL = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pumpUp = 1'b0;
  logic pumpDn = 1'b0;
  logic cmpDone = 1'b0;
  logic precisionSel = 1'b0;
  logic tristateEn = 1'b0;
  logic powerDown = 1'b0;
  logic lockFlag;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  lock_detector #(
    .ENTRY_LIMIT(ENTRY),
    .EXIT_LIMIT (EXITL),
    .RUN_SHORT  (3),
    .RUN_LONG   (5)
  ) u_dut (
    .clk         (clk),
    .rstN        (rstN),
    .pumpUp      (pumpUp),
    .pumpDn      (pumpDn),
    .cmpDone     (cmpDone),
    .precisionSel(precisionSel),
    .tristateEn  (tristateEn),
    .powerDown   (powerDown),
    .lockFlag    (lockFlag)
  );

  task automatic check(input logic got, input logic exp, input string req, input string what);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s: lockFlag=%b expected=%b", req, what, got, exp);
    end
  endtask

  // one comparison: upCyc cycles of pump-up, dnCyc of pump-down, then the strobe
  task automatic compare(input int upCyc, input int dnCyc);
    for (int i = 0; i < upCyc; i++) begin
      @(negedge clk); pumpUp = 1'b1;
    end
    @(negedge clk); pumpUp = 1'b0;
    for (int i = 0; i < dnCyc; i++) begin
      pumpDn = 1'b1; @(negedge clk);
    end
    pumpDn = 1'b0;
    cmpDone = 1'b1;
    @(negedge clk); cmpDone = 1'b0;
  endtask

  task automatic forceClear();
    @(negedge clk); powerDown = 1'b1;
    @(negedge clk); powerDown = 1'b0;
  endtask

  task automatic tReset();
    check(lockFlag, 1'b0, "R1", "after reset");
  endtask

  task automatic tEntryShort();
    forceClear();
    precisionSel = 1'b0;
    compare(2, 0);
    check(lockFlag, 1'b0, "R3", "after first good");
    compare(0, 1);
    check(lockFlag, 1'b0, "R3", "after second good");
    compare(1, 1);
    check(lockFlag, 1'b1, "R3", "third good locks (error 2 split up/down, R2)");
  endtask

  task automatic tEntryLong();
    forceClear();
    precisionSel = 1'b1;
    for (int k = 0; k < 4; k++) compare(1, 0);
    check(lockFlag, 1'b0, "R4", "four good not enough");
    compare(0, 0);
    check(lockFlag, 1'b1, "R4", "fifth good locks");
    precisionSel = 1'b0;
  endtask

  task automatic tRunRestart();
    forceClear();
    compare(1, 0);
    compare(1, 0);
    compare(2, 1);
    check(lockFlag, 1'b0, "R5", "error at entry limit stays unlocked");
    compare(1, 0);
    compare(1, 0);
    check(lockFlag, 1'b0, "R5", "run restarted, two good not enough");
    compare(1, 0);
    check(lockFlag, 1'b1, "R5", "third good after restart locks");
  endtask

  task automatic tHysteresis();
    compare(3, 0);
    check(lockFlag, 1'b1, "R7", "error at entry limit keeps lock");
    compare(3, 3);
    check(lockFlag, 1'b1, "R7", "error at exit limit keeps lock (R2 sum)");
  endtask

  task automatic tDrop();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); pumpUp = 1'b1;
    end
    @(negedge clk); pumpUp = 1'b0; pumpDn = 1'b1;
    @(negedge clk); @(negedge clk); @(negedge clk);
    pumpDn = 1'b0;
    check(lockFlag, 1'b1, "R9", "no change before the strobe");
    cmpDone = 1'b1;
    @(negedge clk); cmpDone = 1'b0;
    check(lockFlag, 1'b0, "R6", "error 7 drops lock");
  endtask

  task automatic tForce();
    forceClear();
    compare(1, 0); compare(1, 0); compare(1, 0);
    check(lockFlag, 1'b1, "R8", "relocked before tristate");
    @(negedge clk); tristateEn = 1'b1;
    @(negedge clk); tristateEn = 1'b0;
    check(lockFlag, 1'b0, "R8", "tristate unlocks");
    compare(1, 0); compare(1, 0);
    @(negedge clk); powerDown = 1'b1;
    @(negedge clk); powerDown = 1'b0;
    compare(1, 0);
    check(lockFlag, 1'b0, "R8", "power-down discarded partial run");
    compare(1, 0); compare(1, 0);
    check(lockFlag, 1'b1, "R8", "full run after power-down locks");
    @(negedge clk); pumpUp = 1'b1;
    @(negedge clk); @(negedge clk); @(negedge clk); @(negedge clk);
    powerDown = 1'b1;
    @(negedge clk); powerDown = 1'b0;
    check(lockFlag, 1'b0, "R8", "power-down unlocks");
    pumpUp = 1'b0;
    cmpDone = 1'b1;
    @(negedge clk); cmpDone = 1'b0;
    compare(1, 0); compare(1, 0);
    check(lockFlag, 1'b1, "R8", "partial error discarded, window counted as good");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tEntryShort();
    tHysteresis();
    tDrop();
    tRunRestart();
    tEntryLong();
    tForce();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: run did not complete, expected finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule